// File: doc/BRIEF.md
# Cycle Counter Unit with Prescale

This block counts cycles of the clock that drives it. It has a 32-bit counter and a control word. Software reaches both through a small register port. The port has an address, a write strobe, write data and read data. The read path is combinational.

The control word does three things:
- It starts and stops counting.
- It selects a divide-by-64 prescale, so the counter advances once per 64 cycles instead of once per cycle.
- It carries a self-clearing command that zeroes the counter.

The counter can be read at any time. A write to the counter loads a new value. While counting is stopped, the loaded value is held. While counting is running, counting continues from the loaded value.

The top byte of the control word identifies the implementer. It is fixed by a parameter at reset. Only a small set of control bits can be changed by software.

Top module: `cyc_count_unit`

## Requirements
- R1: While control bit 0 (enable) is 0, the counter value does not change unless it is written or zeroed.
- R2: While enable is 1 and control bit 3 (prescale select) is 0, the counter increases by one on every clock edge after the edge that captured enable. It wraps from 0xFFFFFFFF to 0x00000000.
- R3: While enable is 1 and prescale select is 1, the counter increases once per 64 enabled cycles. The 6-bit prescale phase returns to zero in three cases: the counter is zeroed, the counter is loaded, or a control write changes prescale select. The first divided step therefore comes on the 64th edge after that event.
- R4: A control write with bit 2 set makes the counter read 0 after that edge. Bit 2 is never stored, so it always reads back as 0.
- R5: A control write updates only bits 0, 3, 4 and 5 (mask 0x39). Every other control bit keeps its value.
- R6: After reset, the control word reads {IMPL_CODE, 24'h000000} and the counter reads 0.
- R7: A write to the counter loads the written value exactly. If enable is 0, the value is then held. If enable is 1, counting proceeds upward from it.
- R8: Byte offset 0x0 selects the control word and 0x4 selects the counter. Any other offset reads as 0, and a write to it changes no state. A read returns the register value present at the start of the access cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counted clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_addr | input | ADDR_W | Byte offset of the access |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from the current state |

## Verification
Some properties are checked every cycle by assertions:
- Holding while disabled.
- Single-cycle stepping without prescale.
- Holding between divided steps.
- The zero command and exact loads.
- Preservation of the masked control bits.
- Bit 2 reading back as 0.
- Zero data from unmapped offsets.

Other behaviour needs the bench's scenarios:
- The exact 64-cycle spacing after a phase clear.
- The wrap at the top of the count.
- The reset value carrying the implementer code.
- Mixed random sequences of control writes, loads and reads checked against a reference model.

// File: rtl/cyc_pkg.sv
package cyc_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned EN_BIT   = 0;
  localparam int unsigned ZERO_BIT = 2;
  localparam int unsigned DIV_BIT  = 3;
  localparam logic [DATA_W-1:0] CTRL_WR_MASK = 32'h0000_0039;

  typedef logic [DATA_W-1:0] word_t;

  typedef struct packed {
    logic ctrl_wr;
    logic cnt_wr;
  } reg_sel_t;
endpackage

// File: rtl/cyc_ctrl_reg.sv
module cyc_ctrl_reg
  import cyc_pkg::*;
#(
  parameter logic [7:0] IMPL_CODE = 8'h41
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  word_t wdata,
  output word_t ctrl,
  output logic  zero_cmd,
  output logic  div_change
);
  localparam word_t RESET_VAL = {IMPL_CODE, 24'h00_0000};

  word_t ctrl_q, ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) begin
      ctrl_d = (ctrl_q & ~CTRL_WR_MASK) | (wdata & CTRL_WR_MASK);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= RESET_VAL;
    end else if (wr_en) begin
      ctrl_q <= ctrl_d;
    end
  end

  assign zero_cmd   = wr_en & wdata[ZERO_BIT];
  assign div_change = wr_en & (wdata[DIV_BIT] != ctrl_q[DIV_BIT]);
  assign ctrl       = ctrl_q;
endmodule

// File: rtl/cyc_prescale.sv
module cyc_prescale #(
  parameter int unsigned PRE_W = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic div_sel,
  input  logic clear,
  output logic tick
);
  localparam logic [PRE_W-1:0] PRE_LAST = {PRE_W{1'b1}};

  logic [PRE_W-1:0] pre_q, pre_d;
  logic             pre_ce;

  assign pre_ce = clear | (run & div_sel);

  always_comb begin
    pre_d = pre_q;
    if (clear) begin
      pre_d = '0;
    end else if (run && div_sel) begin
      pre_d = pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (pre_ce) begin
      pre_q <= pre_d;
    end
  end

  assign tick = run & (~div_sel | (pre_q == PRE_LAST));
endmodule

// File: rtl/cyc_counter.sv
module cyc_counter
  import cyc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  zero_cmd,
  input  logic  load,
  input  word_t load_val,
  input  logic  tick,
  output word_t count
);
  word_t cnt_q, cnt_d;
  logic  cnt_ce;

  assign cnt_ce = zero_cmd | load | tick;

  always_comb begin
    cnt_d = cnt_q;
    if (zero_cmd) begin
      cnt_d = '0;
    end else if (load) begin
      cnt_d = load_val;
    end else if (tick) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
    end
  end

  assign count = cnt_q;
endmodule

// File: rtl/cyc_count_unit.sv
module cyc_count_unit
  import cyc_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter logic [7:0]  IMPL_CODE = 8'h41,
  parameter int unsigned PRE_W     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata
);
  localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_CNT  = ADDR_W'(4);

  reg_sel_t sel;
  word_t    ctrl_q;
  word_t    cnt_q;
  logic     zero_cmd, div_change, tick, pre_clear;

  always_comb begin
    sel.ctrl_wr = reg_we & (reg_addr == OFS_CTRL);
    sel.cnt_wr  = reg_we & (reg_addr == OFS_CNT);
  end

  cyc_ctrl_reg #(.IMPL_CODE(IMPL_CODE)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (sel.ctrl_wr),
    .wdata     (reg_wdata),
    .ctrl      (ctrl_q),
    .zero_cmd  (zero_cmd),
    .div_change(div_change)
  );

  assign pre_clear = zero_cmd | sel.cnt_wr | div_change;

  cyc_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (ctrl_q[EN_BIT]),
    .div_sel(ctrl_q[DIV_BIT]),
    .clear  (pre_clear),
    .tick   (tick)
  );

  cyc_counter u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .zero_cmd(zero_cmd),
    .load    (sel.cnt_wr),
    .load_val(reg_wdata),
    .tick    (tick),
    .count   (cnt_q)
  );

  always_comb begin
    unique case (reg_addr)
      OFS_CTRL: reg_rdata = ctrl_q;
      OFS_CNT:  reg_rdata = cnt_q;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/cyc_count_chk.sv
module cyc_count_chk #(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_we,
  input logic [31:0]       reg_wdata,
  input logic [31:0]       reg_rdata,
  input logic [31:0]       ctrl_q,
  input logic [31:0]       cnt_q
);
  logic a_ctrl, a_cnt, wr_ctrl, wr_cnt, no_wr, unmapped;
  logic [5:0] phase;

  assign a_ctrl   = (reg_addr == ADDR_W'(0));
  assign a_cnt    = (reg_addr == ADDR_W'(4));
  assign wr_ctrl  = reg_we & a_ctrl;
  assign wr_cnt   = reg_we & a_cnt;
  assign no_wr    = ~wr_ctrl & ~wr_cnt;
  assign unmapped = ~a_ctrl & ~a_cnt;

  // Independent phase tracker for the divided mode, following the clear rules of R3.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
    end else if ((wr_ctrl && (reg_wdata[2] || reg_wdata[3] != ctrl_q[3])) || wr_cnt) begin
      phase <= '0;
    end else if (ctrl_q[0] && ctrl_q[3]) begin
      phase <= phase + 1'b1;
    end
  end

  assert_hold_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[0] && no_wr) |=> $stable(cnt_q));

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[0] && !ctrl_q[3] && no_wr) |=> (cnt_q == $past(cnt_q) + 32'd1));

  assert_div_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[0] && ctrl_q[3] && no_wr && phase != 6'd63) |=> $stable(cnt_q));

  assert_div_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[0] && ctrl_q[3] && no_wr && phase == 6'd63) |=> (cnt_q == $past(cnt_q) + 32'd1));

  assert_zero_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && reg_wdata[2]) |=> (cnt_q == 32'd0));

  assert_bit2_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    a_ctrl |-> (reg_rdata[2] == 1'b0));

  assert_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> ((ctrl_q & ~32'h39) == ($past(ctrl_q) & ~32'h39)));

  assert_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> (cnt_q == $past(reg_wdata)));

  assert_unmapped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped |-> (reg_rdata == 32'd0));
endmodule

bind cyc_count_unit cyc_count_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_addr (reg_addr),
  .reg_we   (reg_we),
  .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata),
  .ctrl_q   (ctrl_q),
  .cnt_q    (cnt_q)
);

// File: tb/tb_cyc_count_unit.sv
module tb_cyc_count_unit;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned ADDR_W     = 8;
  localparam logic [7:0]  IMPL       = 8'h41;

  logic              clk;
  logic              rst_n;
  logic [ADDR_W-1:0] reg_addr;
  logic              reg_we;
  logic [31:0]       reg_wdata;
  logic [31:0]       reg_rdata;

  int n_tests;
  int n_fail;
  logic finished;

  logic [31:0] m_ctrl, m_cnt;
  logic [5:0]  m_pre;

  cyc_count_unit #(.ADDR_W(ADDR_W), .IMPL_CODE(IMPL), .PRE_W(6)) dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_addr (reg_addr),
    .reg_we   (reg_we),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] model_read(input logic [ADDR_W-1:0] a);
    if (a == 8'h00) return m_ctrl;
    if (a == 8'h04) return m_cnt;
    return 32'h0;
  endfunction

  // Reference model update for one clock edge, written from R1-style rules (R2, R3, R4, R5, R7, R8).
  task automatic model_edge(input logic [ADDR_W-1:0] a, input logic we, input logic [31:0] wd);
    logic zero, ld, dchg, run, tk;
    zero = we && a == 8'h00 && wd[2];
    ld   = we && a == 8'h04;
    dchg = we && a == 8'h00 && (wd[3] != m_ctrl[3]);
    run  = m_ctrl[0];
    tk   = run && (!m_ctrl[3] || m_pre == 6'd63);
    if (zero)    m_cnt = 32'h0;
    else if (ld) m_cnt = wd;
    else if (tk) m_cnt = m_cnt + 32'd1;
    if (zero || ld || dchg)      m_pre = 6'd0;
    else if (run && m_ctrl[3])   m_pre = m_pre + 6'd1;
    if (we && a == 8'h00) m_ctrl = (m_ctrl & ~32'h39) | (wd & 32'h39);
  endtask

  task automatic cyc(input logic [ADDR_W-1:0] a, input logic we, input logic [31:0] wd);
    reg_addr = a; reg_we = we; reg_wdata = wd;
    @(posedge clk);
    model_edge(a, we, wd);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input string req);
    reg_addr = a; reg_we = 1'b0; reg_wdata = 32'h0;
    #1;
    check(req, reg_rdata, model_read(a));
    cyc(a, 1'b0, 32'h0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(8'h10, 1'b0, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] snap;
    n_tests = 0; n_fail = 0; finished = 1'b0;
    void'($urandom(32'h00C0FFEE));
    reg_addr = '0; reg_we = 1'b0; reg_wdata = '0;
    rst_n = 1'b0;
    m_ctrl = {IMPL, 24'h0}; m_cnt = 32'h0; m_pre = 6'd0;
    #(CLK_PERIOD * 3);
    @(negedge clk);
    rst_n = 1'b1;

    // R6 reset values
    reg_addr = 8'h00; #1;
    check("R6 ctrl reset", reg_rdata, {IMPL, 24'h0});
    reg_addr = 8'h04; #1;
    check("R6 cnt reset", reg_rdata, 32'h0);
    @(negedge clk);

    // R1 disabled hold
    idle(5);
    rd(8'h04, "R1 hold while off");

    // R5 mask: try to write all ones, only 0x39 bits change; R4 bit2 reads zero
    cyc(8'h00, 1'b1, 32'hFFFF_FFFE);
    reg_addr = 8'h00; #1;
    check("R5 R4 masked ctrl", reg_rdata, {IMPL, 24'h0} | 32'h38);
    cyc(8'h00, 1'b1, 32'h0);

    // R7 load while disabled holds
    cyc(8'h04, 1'b1, 32'h1234_5678);
    idle(7);
    reg_addr = 8'h04; #1;
    check("R7 load held", reg_rdata, 32'h1234_5678);

    // R2 enable with no prescale: count 10 cycles
    cyc(8'h00, 1'b1, 32'h1);
    idle(10);
    reg_addr = 8'h04; #1;
    check("R2 per-cycle", reg_rdata, 32'h1234_5678 + 32'd10);

    // R2 wrap and R7 load while enabled
    cyc(8'h04, 1'b1, 32'hFFFF_FFFE);
    idle(3);
    reg_addr = 8'h04; #1;
    check("R2 wrap", reg_rdata, 32'h0000_0001);

    // R4 zero command while enabled
    cyc(8'h00, 1'b1, 32'h5);
    reg_addr = 8'h04; #1;
    check("R4 zero", reg_rdata, 32'h0);

    // R3 prescale spacing of exactly 64 cycles
    cyc(8'h00, 1'b1, 32'h9);
    snap = m_cnt;
    idle(63);
    reg_addr = 8'h04; #1;
    check("R3 before 64", reg_rdata, snap);
    idle(1);
    reg_addr = 8'h04; #1;
    check("R3 at 64", reg_rdata, snap + 32'd1);
    idle(64);
    reg_addr = 8'h04; #1;
    check("R3 second step", reg_rdata, snap + 32'd2);

    // R3 load clears the phase
    idle(20);
    cyc(8'h04, 1'b1, 32'h100);
    idle(63);
    reg_addr = 8'h04; #1;
    check("R3 phase cleared by load", reg_rdata, 32'h100);
    idle(1);
    reg_addr = 8'h04; #1;
    check("R3 step after load", reg_rdata, 32'h101);

    // R8 unmapped offsets read zero, writes ignored
    cyc(8'h08, 1'b1, 32'hFFFF_FFFF);
    cyc(8'h01, 1'b1, 32'hFFFF_FFFF);
    reg_addr = 8'h08; #1;
    check("R8 unmapped read", reg_rdata, 32'h0);
    reg_addr = 8'h00; #1;
    check("R8 ctrl untouched", reg_rdata, m_ctrl);
    reg_addr = 8'h04; #1;
    check("R8 cnt as model", reg_rdata, m_cnt);

    // Random mix against the model (R1..R8)
    for (int it = 0; it < 1500; it++) begin
      int op;
      logic [31:0] wd;
      op = int'($urandom % 10);
      wd = $urandom;
      case (op)
        0: begin
          if ($urandom % 4 != 0) wd[2] = 1'b0;
          cyc(8'h00, 1'b1, wd);
        end
        1: cyc(8'h04, 1'b1, wd);
        2: cyc(8'h0C, 1'b1, wd);
        3, 4: rd(8'h00, "R5 random ctrl");
        5, 6, 7: rd(8'h04, "R2 R3 random cnt");
        8: rd(8'h14, "R8 random unmapped");
        default: idle(int'($urandom % 70));
      endcase
    end
    rd(8'h04, "R7 final cnt");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule